// File: doc/BRIEF.md
# DMA Page Translation Table

This block maps device DMA addresses onto physical pages through a table of translation entries held in on-chip RAM. A device presents an address relative to the start of its DMA window; the block returns the page-aligned form of that address, the physical page taken from the matching entry, a mask that selects the offset inside the page, and a two-bit access permission. Lookups travel through a one-stage pipeline with valid/ready handshakes on both the request and the response side.

Software sets the page size (as a shift amount), the number of live entries and the bus address where the window starts, all at runtime. The entry count is limited by a compile-time maximum. Enabling the table zeroes its live entries one per cycle. A hardware reset zeroes every entry the same way. Disabling the table drops its whole configuration. Host updates arrive on a write port that takes an absolute bus address, and the window start is subtracted from it to find the entry.

Top module: `dma_xlate`

## Requirements
- R1: The two least significant bits of an entry give the response permission, with the codes 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R2: A lookup is in range when (address >> shift) is below the entry count. For such a lookup, the physical page is entry AND pageMask, the returned I/O address is request address AND pageMask, and the offset mask is NOT pageMask. Here pageMask is all ones shifted left by the shift.
- R3: A lookup that is not in range returns physical page 0, I/O address 0, an all-ones offset mask and permission 0.
- R4: After reset the table is disabled and all MAX_ENTRIES entries are zeroed at one per cycle, so reqReady stays low for the first MAX_ENTRIES clock edges. An accepted enable zeroes entries 0 to count-1 in the same way, and reqReady stays low for count cycles.
- R5: A disable pulse sets the entry count, the shift and the window start to zero. Every later lookup then returns the result of R3. Disable wins over an enable in the same cycle.
- R6: An enable while the table is enabled (count nonzero) is ignored. The configuration and the entries stay as they were, and no zeroing walk starts.
- R7: A host write stores wrData at index (wrAddr - windowStart) >> shift, using wrap-around subtraction. The write is ignored if that index is not below the count, or while a zeroing walk is running.
- R8: A request accepted on one edge produces rspValid after that edge. While rspValid is high and rspReady is low, the response holds still and reqReady is low. rspValid is low after reset.
- R9: An enable count larger than MAX_ENTRIES is clamped to MAX_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Enable pulse; loads the configuration below |
| cfgDisable | input | 1 | Disable pulse |
| cfgShift | input | SHIFT_W | Page shift for enable |
| cfgCount | input | ADDR_W | Entry count for enable |
| cfgOffset | input | ADDR_W | Window start bus address for enable |
| wrEn | input | 1 | Host entry write strobe |
| wrAddr | input | ADDR_W | Absolute bus address of the entry to write |
| wrData | input | ADDR_W | Entry value |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Lookup request ready |
| reqAddr | input | ADDR_W | Window-relative lookup address |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response ready |
| rspIoAddr | output | ADDR_W | Page-aligned I/O address |
| rspPhysAddr | output | ADDR_W | Translated physical page address |
| rspMask | output | ADDR_W | In-page offset mask |
| rspPerm | output | 2 | Access permission |

## Verification
The bench builds the block with ADDR_W = 16 and MAX_ENTRIES = 16. At that size every entry index, plus two indices past the end, can be swept under page shifts of 2, 4 and 6. Each sweep uses its own window start, and one start sits near the top of the address space, where the host-write subtraction wraps. The small depth makes the reset and enable zeroing walks short enough to time exactly. It also lets a count request of 40 reach the clamp, where entry 15 stays live and entry 16 faults.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef struct packed {
    logic accept;
    logic ramWe;
    logic clearSel;
  } strobe_t;

endpackage

// File: rtl/dma_xlate_ctrl.sv
module dma_xlate_ctrl
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 512,
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int SHIFT_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgDisable,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [ADDR_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0]  cfgOffset,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               reqValid,
  input  logic               rspReady,
  output logic               reqReady,
  output logic               rspValid,
  output strobe_t            stb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [SHIFT_W-1:0] shiftQ,
  output logic [CNT_W-1:0]   countQ
);

  logic [ADDR_W-1:0] offsetQ;
  logic              clearing;
  logic [CNT_W-1:0]  clrIdx;
  logic [CNT_W-1:0]  clrLimit;
  logic              s1Valid;
  logic [CNT_W-1:0]  newCount;
  logic              enableGo;
  logic [ADDR_W-1:0] hostOff;
  logic [ADDR_W-1:0] hostIdx;
  logic              hostHit;

  // Enable is honoured only from the disabled state (R6); count is clamped (R9)
  always_comb begin
    newCount = (cfgCount > ADDR_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES)
                                                 : cfgCount[CNT_W-1:0];
    enableGo = cfgEnable && !cfgDisable && (countQ == '0) && (cfgCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      shiftQ  <= '0;
      offsetQ <= '0;
    end else if (cfgDisable) begin
      countQ  <= '0;
      shiftQ  <= '0;
      offsetQ <= '0;
    end else if (enableGo) begin
      countQ  <= newCount;
      shiftQ  <= cfgShift;
      offsetQ <= cfgOffset;
    end
  end

  // Zeroing walk: all entries after reset, the live range after enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearing <= 1'b1;
      clrIdx   <= '0;
      clrLimit <= CNT_W'(MAX_ENTRIES);
    end else if (enableGo) begin
      clearing <= 1'b1;
      clrIdx   <= '0;
      clrLimit <= newCount;
    end else if (clearing) begin
      if (clrIdx == clrLimit - CNT_W'(1)) clearing <= 1'b0;
      clrIdx <= clrIdx + CNT_W'(1);
    end
  end

  // Host write decode against the live window
  always_comb begin
    hostOff = wrAddr - offsetQ;
    hostIdx = hostOff >> shiftQ;
    hostHit = wrEn && !clearing && (hostIdx < ADDR_W'(countQ));
  end

  // Pipeline occupancy and handshakes
  always_comb begin
    reqReady     = !clearing && (!s1Valid || rspReady);
    stb.accept   = reqValid && reqReady;
    stb.ramWe    = clearing || hostHit;
    stb.clearSel = clearing;
    wrIdx        = clearing ? clrIdx[IDX_W-1:0] : hostIdx[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           s1Valid <= 1'b0;
    else if (stb.accept) s1Valid <= 1'b1;
    else if (rspReady)   s1Valid <= 1'b0;
  end

  assign rspValid = s1Valid;

endmodule

// File: rtl/dma_xlate_dp.sv
module dma_xlate_dp
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 512,
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int SHIFT_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [SHIFT_W-1:0] shiftQ,
  input  logic [CNT_W-1:0]   countQ,
  output logic [ADDR_W-1:0]  rspIoAddr,
  output logic [ADDR_W-1:0]  rspPhysAddr,
  output logic [ADDR_W-1:0]  rspMask,
  output logic [1:0]         rspPerm
);

  logic [ADDR_W-1:0] mem [MAX_ENTRIES];
  logic [ADDR_W-1:0] ramQ;
  logic [ADDR_W-1:0] pageMask;
  logic [ADDR_W-1:0] idxFull;
  logic              inRange;
  logic              s1InRange;
  logic [ADDR_W-1:0] s1Addr;
  logic [ADDR_W-1:0] s1PageMask;
  perm_e             permSel;

  always_comb begin
    pageMask = {ADDR_W{1'b1}} << shiftQ;
    idxFull  = reqAddr >> shiftQ;
    inRange  = idxFull < ADDR_W'(countQ);
  end

  always_ff @(posedge clk) begin
    if (stb.ramWe) mem[wrIdx] <= stb.clearSel ? '0 : wrData;
    if (stb.accept) ramQ <= mem[idxFull[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1InRange  <= 1'b0;
      s1Addr     <= '0;
      s1PageMask <= '0;
    end else if (stb.accept) begin
      s1InRange  <= inRange;
      s1Addr     <= reqAddr;
      s1PageMask <= pageMask;
    end
  end

  always_comb begin
    permSel = perm_e'(ramQ[1:0]);
    if (s1InRange) begin
      rspIoAddr   = s1Addr & s1PageMask;
      rspPhysAddr = ramQ & s1PageMask;
      rspMask     = ~s1PageMask;
      rspPerm     = permSel;
    end else begin
      rspIoAddr   = '0;
      rspPhysAddr = '0;
      rspMask     = '1;
      rspPerm     = PERM_NONE;
    end
  end

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 512,
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int SHIFT_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgDisable,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [ADDR_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0]  cfgOffset,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [ADDR_W-1:0]  rspIoAddr,
  output logic [ADDR_W-1:0]  rspPhysAddr,
  output logic [ADDR_W-1:0]  rspMask,
  output logic [1:0]         rspPerm
);

  strobe_t            stb;
  logic [IDX_W-1:0]   wrIdx;
  logic [SHIFT_W-1:0] shiftQ;
  logic [CNT_W-1:0]   countQ;

  dma_xlate_ctrl #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgDisable(cfgDisable),
    .cfgShift(cfgShift), .cfgCount(cfgCount), .cfgOffset(cfgOffset),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .reqValid(reqValid), .rspReady(rspReady),
    .reqReady(reqReady), .rspValid(rspValid),
    .stb(stb), .wrIdx(wrIdx), .shiftQ(shiftQ), .countQ(countQ)
  );

  dma_xlate_dp #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) uDp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .wrIdx(wrIdx), .wrData(wrData),
    .reqAddr(reqAddr), .shiftQ(shiftQ), .countQ(countQ),
    .rspIoAddr(rspIoAddr), .rspPhysAddr(rspPhysAddr),
    .rspMask(rspMask), .rspPerm(rspPerm)
  );

endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 512,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] rspIoAddr,
  input logic [ADDR_W-1:0] rspPhysAddr,
  input logic [ADDR_W-1:0] rspMask,
  input logic [1:0]        rspPerm
);

  logic [CNT_W-1:0] bootCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootCnt <= '0;
    else if (bootCnt < CNT_W'(MAX_ENTRIES)) bootCnt <= bootCnt + CNT_W'(1);
  end

  AST_BOOT_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (bootCnt < CNT_W'(MAX_ENTRIES)) |-> !reqReady); // R4

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspIoAddr) && $stable(rspPhysAddr)
                                 && $stable(rspMask) && $stable(rspPerm))); // R8

  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> !reqReady); // R8

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R8

  AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspMask == '1)) |-> (rspPhysAddr == '0 && rspIoAddr == '0
                                       && rspPerm == 2'd0)); // R3

  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspPhysAddr & rspMask) == '0 && (rspIoAddr & rspMask) == '0)); // R2

endmodule

bind dma_xlate dma_xlate_chk #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspReady(rspReady), .rspIoAddr(rspIoAddr),
  .rspPhysAddr(rspPhysAddr), .rspMask(rspMask), .rspPerm(rspPerm)
);

// File: tb/tb_dma_xlate.sv
`timescale 1ns/1ps
module tb_dma_xlate;
  localparam int AW  = 16;
  localparam int MAX = 16;
  localparam int SW  = $clog2(AW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEnable = 0, cfgDisable = 0;
  logic [SW-1:0] cfgShift = '0;
  logic [AW-1:0] cfgCount = '0, cfgOffset = '0;
  logic          wrEn = 0;
  logic [AW-1:0] wrAddr = '0, wrData = '0;
  logic          reqValid = 0, rspReady = 1;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady, rspValid;
  logic [AW-1:0] rspIoAddr, rspPhysAddr, rspMask;
  logic [1:0]    rspPerm;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0] mdl [MAX];
  int mCount = 0, mShift = 0;
  logic [AW-1:0] mOffset = '0;

  always #2 clk = ~clk;

  dma_xlate #(.ADDR_W(AW), .MAX_ENTRIES(MAX)) dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDisable(cfgDisable),
    .cfgShift(cfgShift), .cfgCount(cfgCount), .cfgOffset(cfgOffset),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspIoAddr(rspIoAddr),
    .rspPhysAddr(rspPhysAddr), .rspMask(rspMask), .rspPerm(rspPerm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [49:0] expected(input logic [AW-1:0] a);
    logic [AW-1:0] pm;
    int idx;
    pm  = 16'hFFFF << mShift;
    idx = int'(a >> mShift);
    if (idx < mCount) return {a & pm, mdl[idx] & pm, ~pm, mdl[idx][1:0]};
    return {16'h0, 16'h0, 16'hFFFF, 2'b00};
  endfunction

  task automatic lookup(input logic [AW-1:0] a, input string req);
    logic [49:0] exp;
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    exp = expected(a);
    check(rspValid == 1'b1, req, "rspValid one cycle after accept", 64'(rspValid), 64'd1);
    check({rspIoAddr, rspPhysAddr, rspMask, rspPerm} == exp, req, "lookup {io,phys,mask,perm}",
          64'({rspIoAddr, rspPhysAddr, rspMask, rspPerm}), 64'(exp));
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [AW-1:0] d);
    logic [AW-1:0] idx;
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    idx = (a - mOffset) >> mShift;
    if (int'(idx) < mCount) mdl[idx] = d;
  endtask

  // Pulse enable; on the following negedge a host write is attempted (must be
  // ignored while zeroing, R7), then the cycles with reqReady low are counted.
  task automatic enable(input int sh, input int cnt, input logic [AW-1:0] off, input string req);
    int lows = 0;
    int expLows = 0;
    @(negedge clk);
    cfgEnable = 1; cfgShift = SW'(sh); cfgCount = AW'(cnt); cfgOffset = off;
    if (mCount == 0 && cnt != 0) begin
      mCount = (cnt > MAX) ? MAX : cnt;
      mShift = sh; mOffset = off;
      for (int i = 0; i < MAX; i++) mdl[i] = '0;
      expLows = mCount;
    end
    @(negedge clk);
    cfgEnable = 0;
    wrEn = 1; wrAddr = mOffset + AW'(1 << mShift); wrData = 16'hBEEF;
    for (int k = 0; k < 100; k++) begin
      if (reqReady) break;
      lows++;
      @(negedge clk);
      wrEn = 0;
    end
    wrEn = 0;
    check(lows == expLows, req, "cycles with reqReady low after enable", 64'(lows), 64'(expLows));
  endtask

  task automatic disable_table();
    @(negedge clk);
    cfgDisable = 1;
    @(negedge clk);
    cfgDisable = 0;
    mCount = 0; mShift = 0; mOffset = '0;
  endtask

  task automatic fill();
    for (int i = 0; i < MAX; i++)
      hostWrite(mOffset + AW'(i << mShift) + AW'(i & ((1 << mShift) - 1)),
                AW'(i * 16'h0A35 + mShift * 16'h1111 + 7));
    // below window start: wraps to a huge index and must be ignored (R7)
    hostWrite(mOffset - AW'(1 << mShift), 16'hFFFF);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < MAX + 2; i++)
      lookup(AW'((i << mShift) | ((i * 5 + 3) & ((1 << mShift) - 1))), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] hIo, hPh, hMk;
    logic [1:0]    hPm;
    logic [49:0]   expB;
    int lows;
    for (int i = 0; i < MAX; i++) mdl[i] = '0;

    // Reset: zeroing walk over all MAX entries (R4), no response pending (R8)
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R8", "rspValid in reset", 64'(rspValid), 64'd0);
    rstN = 1;
    lows = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (reqReady) break;
      lows++;
    end
    // walk ends on edge MAX; negedges after edges 1..MAX-1 see reqReady low
    check(lows == MAX - 1, "R4", "reset walk length", 64'(lows), 64'(MAX - 1));

    // Disabled after reset: everything faults (R3, R5)
    sweep("R3");
    hostWrite(16'h0000, 16'h1234);
    lookup(16'h0000, "R5");

    // Config A: shift 4, count 8, start 0x0200
    enable(4, 8, 16'h0200, "R4");
    lookup(16'h0010, "R7"); // write attempted during zeroing must be gone
    fill();
    sweep("R1/R2");

    // Second enable while enabled is ignored (R6)
    enable(6, 4, 16'h0000, "R6");
    sweep("R6");

    // Disable: every lookup faults (R5)
    disable_table();
    sweep("R5");
    hostWrite(16'h0000, 16'h5555);
    lookup(16'h0000, "R5");

    // Config B: shift 2, count 40 clamped to 16, start near top (R9, R7 wrap)
    enable(2, 40, 16'hFFE0, "R9");
    fill();
    sweep("R9");
    lookup(AW'(15 << 2), "R9");
    lookup(AW'(16 << 2), "R9");

    // Config C: shift 6, count 5, start 0; enable with disable in same cycle
    disable_table();
    @(negedge clk);
    cfgEnable = 1; cfgDisable = 1; cfgShift = 4'd3; cfgCount = 16'd4;
    @(negedge clk);
    cfgEnable = 0; cfgDisable = 0;
    check(reqReady == 1'b1, "R5", "disable beats enable (no zeroing walk)", 64'(reqReady), 64'd1);
    lookup(16'h0000, "R5");
    enable(6, 5, 16'h0000, "R2");
    fill();
    sweep("R2");

    // Backpressure (R8)
    @(negedge clk);
    rspReady = 0; reqValid = 1; reqAddr = AW'(2 << 6);
    @(negedge clk);
    check(rspValid == 1'b1, "R8", "rspValid after accept", 64'(rspValid), 64'd1);
    check(reqReady == 1'b0, "R8", "reqReady low while stalled", 64'(reqReady), 64'd0);
    hIo = rspIoAddr; hPh = rspPhysAddr; hMk = rspMask; hPm = rspPerm;
    check({hIo, hPh, hMk, hPm} == expected(AW'(2 << 6)), "R8", "first stalled response",
          64'({hIo, hPh, hMk, hPm}), 64'(expected(AW'(2 << 6))));
    reqAddr = AW'(3 << 6);
    repeat (3) @(negedge clk);
    check({rspValid, rspIoAddr, rspPhysAddr, rspMask, rspPerm} == {1'b1, hIo, hPh, hMk, hPm},
          "R8", "response held under stall",
          64'({rspIoAddr, rspPhysAddr, rspMask, rspPerm}), 64'({hIo, hPh, hMk, hPm}));
    rspReady = 1;
    @(negedge clk);
    reqValid = 0;
    expB = expected(AW'(3 << 6));
    check(rspValid == 1'b1, "R8", "second response valid", 64'(rspValid), 64'd1);
    check({rspIoAddr, rspPhysAddr, rspMask, rspPerm} == expB, "R8", "second response",
          64'({rspIoAddr, rspPhysAddr, rspMask, rspPerm}), 64'(expB));
    @(negedge clk);
    check(rspValid == 1'b0, "R8", "response drained", 64'(rspValid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule